// File: doc/BRIEF.md
# Double-Buffered PWM Channel Generator

This block produces one pulse-width-modulated output from a private time base. Software programs a duty compare value and a period compare value through a small write port. Each value first lands in a holding buffer. The buffers are copied into the active compare registers only when the counter wraps at the end of a period, so a reprogramming never yields a torn or glitched period. While the channel is disabled, the active registers follow the buffers, so the first period after enabling uses the latest values.

The counter advances only on clocks where the prescale tick input is high. It runs from 1 up to the active period value and then returns to 1. When the counter's stay at the duty value ends, the output goes to its active level. When the counter's stay at the period value ends, the output goes back to the inactive level. Each pin change therefore lands one system clock after the tick that moves the counter off the matching value. A polarity bit chooses which pin level counts as active. Constant-active and constant-inactive outputs are both available.

Top module: `pwmb_channel`

## Requirements
- R1: While reset is high, the counter becomes 1, all buffers, active compare values and the polarity bit clear to 0, and the output sits at the inactive level, so pwm_o = 1 after reset.
- R2: When enabled, the counter never holds 0. On an advancing tick at the active period value, it returns to 1, so one period lasts exactly period ticks.
- R3: The end of the counter's stay at the active duty value moves the output to the active level (pwm_o equals the polarity bit). The pin changes one system clock after the tick that leaves the duty value.
- R4: The end of the counter's stay at the active period value moves the output to the inactive level (pwm_o equals the inverted polarity bit), with the same one-clock delay. Per period, the output is active for (period - duty) ticks.
- R5: Writes to the duty code (wr_sel_i = 2'b00) or the period code (wr_sel_i = 2'b01) go to buffers. While enabled, the active values change only at the period wrap, and both change together.
- R6: The counter advances only on clocks with tick_i high. A tick on every second clock doubles every output time.
- R7: When duty equals period, both ends coincide and the set wins, so the output stays at the active level (100% duty).
- R8: When duty exceeds period, no duty match occurs, so the output stays at the inactive level (0% duty).
- R9: A period write of 0 or 1 is ignored, and the period buffer keeps its previous value.
- R10: Writing wr_sel_i = 2'b10 loads wr_data_i bit 0 as the polarity bit. The output reflects the new polarity on the next clock, without waiting for a period wrap. wr_sel_i = 2'b11 has no effect.
- R11: While chan_en_i is low, the counter and the output level hold. After re-enabling, counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled count enable |
| chan_en_i | input | 1 | Channel enable. Raise it only while the counter is below the buffered period |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 00 duty, 01 period, 10 polarity, 11 none |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | 1 | PWM output pin |

## Verification
The main function is driven with several shapes. Duty 4 of period 10 at full rate gives active time 6 of 10. A live change to duty 7 must move the active time only after the wrap. Duty 1 of period 5 with a tick every second clock shows that the prescale stretches every time by two. Equal duty and period, and duty larger than period, separate the two saturated outputs and show which end wins when both coincide. A scoreboard compares every clock against a reference built from the requirements, so the one-clock pin delay and the wrap timing are checked cycle by cycle.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

    typedef enum logic [1:0] {
        SEL_DUTY   = 2'b00,
        SEL_PERIOD = 2'b01,
        SEL_POL    = 2'b10,
        SEL_NONE   = 2'b11
    } pwmb_sel_e;

    localparam int unsigned NUM_CMP    = 2;
    localparam int unsigned CMP_DUTY   = 0;
    localparam int unsigned CMP_PERIOD = 1;

    typedef struct packed {
        logic period;
        logic duty;
    } pwmb_evt_t;

    // Output level update: a duty end sets, a period end clears, set wins.
    function automatic logic next_level(input logic cur, input pwmb_evt_t ev);
        logic lvl;
        lvl = cur;
        if (ev.period) lvl = 1'b0;
        if (ev.duty)   lvl = 1'b1;
        return lvl;
    endfunction

endpackage

// File: rtl/pwmb_regbank.sv
module pwmb_regbank
    import pwmb_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  pwmb_sel_e     wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          chan_en,
    input  logic          wrap,
    output logic [CW-1:0] period_buf,
    output logic [CW-1:0] duty_act,
    output logic [CW-1:0] period_act,
    output logic          pol
);

    localparam logic [CW-1:0] MIN_PERIOD = CW'(2);

    logic [CW-1:0] duty_buf;
    logic          period_ok;

    assign period_ok = (wr_data >= MIN_PERIOD);

    // Holding buffers and polarity
    always_ff @(posedge clk) begin
        if (rst) begin
            duty_buf   <= '0;
            period_buf <= '0;
            pol        <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_DUTY:   duty_buf <= wr_data;
                SEL_PERIOD: if (period_ok) period_buf <= wr_data;
                SEL_POL:    pol <= wr_data[0];
                default:    ;
            endcase
        end
    end

    // Active compare values: transparent while idle, copied at wrap while running
    always_ff @(posedge clk) begin
        if (rst) begin
            duty_act   <= '0;
            period_act <= '0;
        end else if (!chan_en || wrap) begin
            duty_act   <= duty_buf;
            period_act <= period_buf;
        end
    end

endmodule

// File: rtl/pwmb_timebase.sv
module pwmb_timebase
    import pwmb_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_en,
    input  logic          tick,
    input  logic [CW-1:0] duty_act,
    input  logic [CW-1:0] period_act,
    output logic [CW-1:0] cnt,
    output pwmb_evt_t     match,
    output logic          advance,
    output logic          wrap
);

    localparam logic [CW-1:0] CNT_START = CW'(1);

    assign advance      = chan_en && tick;
    assign match.duty   = chan_en && (cnt == duty_act);
    assign match.period = chan_en && (cnt == period_act);
    assign wrap         = advance && match.period;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_START;
        end else if (advance) begin
            cnt <= wrap ? CNT_START : cnt + CNT_START;
        end
    end

endmodule

// File: rtl/pwmb_outstage.sv
module pwmb_outstage
    import pwmb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      advance,
    input  pwmb_evt_t match,
    input  logic      pol,
    output pwmb_evt_t evt,
    output logic      act,
    output logic      pwm
);

    logic [NUM_CMP-1:0] mvec;
    logic [NUM_CMP-1:0] evec;

    assign mvec[CMP_DUTY]   = match.duty;
    assign mvec[CMP_PERIOD] = match.period;

    // End-of-match strobes: a match that is present when the counter moves on
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_end
        always_ff @(posedge clk) begin
            if (rst) evec[i] <= 1'b0;
            else     evec[i] <= advance && mvec[i];
        end
    end

    assign evt.duty   = evec[CMP_DUTY];
    assign evt.period = evec[CMP_PERIOD];

    always_ff @(posedge clk) begin
        if (rst) act <= 1'b0;
        else     act <= next_level(act, evt);
    end

    assign pwm = act ? pol : ~pol;

endmodule

// File: rtl/pwmb_channel.sv
module pwmb_channel
    import pwmb_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             chan_en_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             pwm_o
);

    logic [CNT_W-1:0] period_buf;
    logic [CNT_W-1:0] duty_act;
    logic [CNT_W-1:0] period_act;
    logic [CNT_W-1:0] cnt_q;
    logic             pol_q;
    logic             advance;
    logic             wrap;
    logic             act_q;
    pwmb_evt_t        match;
    pwmb_evt_t        evt_q;

    pwmb_regbank #(.CW(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en_i),
        .wr_sel     (pwmb_sel_e'(wr_sel_i)),
        .wr_data    (wr_data_i),
        .chan_en    (chan_en_i),
        .wrap       (wrap),
        .period_buf (period_buf),
        .duty_act   (duty_act),
        .period_act (period_act),
        .pol        (pol_q)
    );

    pwmb_timebase #(.CW(CNT_W)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en_i),
        .tick       (tick_i),
        .duty_act   (duty_act),
        .period_act (period_act),
        .cnt        (cnt_q),
        .match      (match),
        .advance    (advance),
        .wrap       (wrap)
    );

    pwmb_outstage u_out (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .match   (match),
        .pol     (pol_q),
        .evt     (evt_q),
        .act     (act_q),
        .pwm     (pwm_o)
    );

endmodule

// File: rtl/pwmb_channel_chk.sv
module pwmb_channel_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          tick,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] period_act,
    input logic [CW-1:0] duty_act,
    input logic [CW-1:0] period_buf,
    input logic          ev_duty,
    input logic          ev_period,
    input logic          act
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cnt == CW'(1)) && !act);

    assert_no_zero_count_R2: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);

    assert_wrap_to_one_R2: assert property (@(posedge clk) disable iff (rst)
        en && tick && (cnt == period_act) |=> cnt == CW'(1));

    assert_duty_sets_R3: assert property (@(posedge clk) disable iff (rst)
        ev_duty |=> act);

    assert_period_clears_R4: assert property (@(posedge clk) disable iff (rst)
        ev_period && !ev_duty |=> !act);

    assert_buffered_update_R5: assert property (@(posedge clk) disable iff (rst)
        en && !(tick && (cnt == period_act)) |=> $stable(duty_act) && $stable(period_act));

    assert_tick_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    assert_period_legal_R9: assert property (@(posedge clk) disable iff (rst)
        period_buf != CW'(1));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !en && !ev_duty && !ev_period |=> $stable(cnt) && $stable(act));

endmodule

bind pwmb_channel pwmb_channel_chk #(.CW(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (chan_en_i),
    .tick       (tick_i),
    .cnt        (cnt_q),
    .period_act (period_act),
    .duty_act   (duty_act),
    .period_buf (period_buf),
    .ev_duty    (evt_q.duty),
    .ev_period  (evt_q.period),
    .act        (act_q)
);

// File: tb/sim_pwmb_channel.sv
`timescale 1ns/1ps
module sim_pwmb_channel;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b1;
    logic          en = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'b11;
    logic [CW-1:0] wr_data = '0;
    logic          pwm;

    int    vectors = 0;
    int    miscompares = 0;
    int    presc = 1;
    int    divcnt = 0;
    string cur_req = "R1";
    bit    exp_q[$];

    always #2 clk = ~clk;

    pwmb_channel #(.CNT_W(CW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .chan_en_i (en),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .pwm_o     (pwm)
    );

    // Reference model: pushes the expected pin after every rising edge
    int unsigned m_cnt = 1, m_db = 0, m_pb = 0, m_da = 0, m_pa = 0;
    bit m_pol = 0, m_evd = 0, m_evp = 0, m_act = 0;
    always @(posedge clk) begin : model
        bit adv, at_end, n_act, n_evd, n_evp;
        int unsigned n_cnt, n_da, n_pa;
        if (rst) begin
            m_cnt = 1; m_db = 0; m_pb = 0; m_da = 0; m_pa = 0;
            m_pol = 0; m_evd = 0; m_evp = 0; m_act = 0;
        end else begin
            adv    = en && tick;
            at_end = adv && (m_cnt == m_pa);
            n_act  = m_evd ? 1'b1 : (m_evp ? 1'b0 : m_act);
            n_evd  = adv && (m_cnt == m_da);
            n_evp  = at_end;
            n_cnt  = adv ? (at_end ? 1 : m_cnt + 1) : m_cnt;
            n_da   = m_da;
            n_pa   = m_pa;
            if (!en || at_end) begin
                n_da = m_db;
                n_pa = m_pb;
            end
            if (wr_en) begin
                case (wr_sel)
                    2'b00: m_db = wr_data;
                    2'b01: if (wr_data >= 2) m_pb = wr_data;
                    2'b10: m_pol = wr_data[0];
                    default: ;
                endcase
            end
            m_act = n_act; m_evd = n_evd; m_evp = n_evp;
            m_cnt = n_cnt; m_da = n_da; m_pa = n_pa;
        end
        exp_q.push_back(m_act ? m_pol : !m_pol);
    end

    // Prescale tick generator and scoreboard monitor, both away from the rising edge
    always @(negedge clk) begin
        if (presc <= 1) begin
            tick   = 1'b1;
            divcnt = 0;
        end else begin
            tick   = (divcnt == presc - 1);
            divcnt = (divcnt == presc - 1) ? 0 : divcnt + 1;
        end
    end

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            vectors++;
            if (pwm !== e) begin
                miscompares++;
                $display("FAIL %s: pwm_o=%0b expected %0b at %0t", cur_req, pwm, e, $time);
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = CW'(val);
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm === 1'b1) hi++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        int hi;
        logic held;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset level", pwm, 1);

        cur_req = "R10";
        wr(2'b10, 1);
        check("R10 polarity high", pwm, 0);
        wr(2'b10, 32'h2);
        check("R10 polarity bit0 only", pwm, 1);
        wr(2'b11, 1);
        check("R10 code 11 no effect", pwm, 1);
        wr(2'b10, 1);
        check("R10 polarity restored", pwm, 0);

        cur_req = "R2 R3 R4 R9";
        wr(2'b00, 4);
        wr(2'b01, 10);
        wr(2'b01, 1);
        wr(2'b01, 0);
        @(negedge clk); en = 1'b1;
        idle(20);
        count_high(100, hi);
        check("R9 period writes below 2 ignored, R3 R4 active 6 of 10", hi, 60);

        cur_req = "R5";
        idle(3);
        wr(2'b00, 7);
        idle(20);
        count_high(100, hi);
        check("R5 duty 7 of 10", hi, 30);

        cur_req = "R6";
        presc = 2;
        wr(2'b01, 5);
        wr(2'b00, 1);
        idle(40);
        count_high(100, hi);
        check("R6 prescale 2 duty 1 of 5", hi, 80);

        cur_req = "R7";
        presc = 1;
        wr(2'b00, 6);
        wr(2'b01, 6);
        idle(30);
        count_high(60, hi);
        check("R7 equal duty and period", hi, 60);

        cur_req = "R8";
        wr(2'b00, 9);
        idle(30);
        count_high(60, hi);
        check("R8 duty above period", hi, 0);

        cur_req = "R11";
        wr(2'b00, 2);
        wr(2'b01, 8);
        idle(30);
        while (pwm !== 1'b1) @(negedge clk);
        en = 1'b0;
        held = pwm;
        idle(25);
        check("R11 pin held while disabled", pwm, held);
        en = 1'b1;
        idle(20);
        count_high(80, hi);
        check("R11 resumes duty 2 of 8", hi, 60);

        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule